// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block takes in asynchronous serial characters on one input line. Software sets the framing at run time. A character holds 5 to 9 data bits, parity can be even, odd or absent, and the frame can end with 1, 2 or 3 stop bits. A programmable clock divisor and an oversampling select (16x or 8x) set the bit rate. The receiver makes its own sample tick from these two settings. The line first passes through a two-flop synchroniser. A falling edge starts a frame, and the start bit is confirmed half a bit period later. Each later bit is decided by a majority vote of three samples taken around the bit centre.

A finished character is placed in a holding register and raises a data-ready flag. A one-cycle read pulse clears that flag. Framing, parity and overrun errors are kept as sticky flags until a one-cycle clear pulse removes them. A ready-to-send output goes low while the holding register is occupied, which tells the far end to pause. An optional address mode works with 9-bit characters and is used on shared lines with several receivers. In this mode a character with its top bit set is an address. Data characters are thrown away silently until an address equal to the node address arrives.

The frame state machine has five states:
- ST_IDLE waits for a low sample on a tick and then moves to ST_START.
- ST_START goes back to ST_IDLE if the line is high at the half-bit check (glitch). Otherwise it moves to ST_DATA at the end of the bit.
- ST_DATA moves on after the last data bit. It goes to ST_PARITY when parity is enabled, and to ST_STOP when it is not.
- ST_PARITY moves to ST_STOP after one bit.
- ST_STOP returns to ST_IDLE after the last stop bit and issues the completion pulse.

Top module: `serial_rx_core`

## Requirements
- R1: The data-bit count is `data_bits` (values below 5 act as 5, values above 9 act as 9). Bits arrive LSB first. The character is right-aligned in `rx_data`, and the unused upper bits read as zero.
- R2: `parity_mode` selects the parity: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 means no parity bit. With parity enabled, a parity bit that does not match the received data sets `err_parity`. `err_parity` never rises while parity is disabled.
- R3: One bit lasts max(`divisor`,1) × 16 clocks when `os_sel`=0, and max(`divisor`,1) × 8 clocks when `os_sel`=1. Characters sent at that rate are received correctly. Two sample ticks are never on adjacent cycles when the divisor is above 1.
- R4: `stop_bits` selects the stop-bit count: 0 or 1 gives one stop bit, 2 gives two, 3 gives three. A low majority on any stop bit sets `err_frame`, and the character is still delivered.
- R5: A delivered character loads `rx_data` and sets `data_ready`. `rx_data` stays unchanged while `data_ready` is set and no read happens. A `rd_pulse` clears `data_ready`.
- R6: A character that completes while `data_ready` is still set (and no read happens in that cycle) sets `err_overrun`. The old character is kept in `rx_data`.
- R7: A low level that has gone high again by the half-bit check is ignored. It delivers nothing and sets no flag, and the next real character is still received.
- R8: With `addr_mode`=1 and 9 data bits, a character whose bit 8 is set is an address. If its low 8 bits equal `node_addr` it is delivered and enables data reception. Otherwise it is discarded and disables data reception. Data characters (bit 8 clear) are discarded without any flag while reception is disabled, which is the state after reset.
- R9: `rts` is high when the receiver can accept a character and low whenever `data_ready` is set.
- R10: `err_clr` clears `err_frame`, `err_parity` and `err_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| divisor | input | DIV_W | Clocks per sample tick (0 acts as 1) |
| os_sel | input | 1 | 0: 16x oversampling, 1: 8x |
| data_bits | input | 4 | Data bits per character, 5..9 |
| parity_mode | input | 2 | 01 even, 10 odd, otherwise none |
| stop_bits | input | 2 | Stop-bit count 1..3 (0 acts as 1) |
| addr_mode | input | 1 | Enable 9-bit address filtering |
| node_addr | input | 8 | This node's address |
| rd_pulse | input | 1 | One-cycle read of the holding register |
| err_clr | input | 1 | One-cycle clear of the error flags |
| rx_data | output | 9 | Holding register, right-aligned |
| data_ready | output | 1 | Holding register holds an unread character |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| rts | output | 1 | High when ready to accept a character |

## Verification
The assertions check on every cycle that:
- sample ticks are spaced apart;
- the data-bit counter stays inside the configured width;
- parity errors appear only when parity is enabled;
- overrun appears only while a character is pending;
- `data_ready` falls only after a read;
- the held character stays stable until it is read;
- `rts` is low whenever a character is pending.

Only the directed scenarios can show the rest. This includes correct bit values across the different widths, rates and oversampling choices, and detection of bad parity and bad stop bits. It also includes rejection of a short start glitch, address filtering over a sequence of address and data characters, and the clearing of the flags.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int MAX_BITS = 9;
    localparam int MIN_BITS = 5;
    localparam int ADR_W    = MAX_BITS - 1;
    localparam int OS_HI    = 16;
    localparam int OS_LO    = 8;
    localparam int OSC_W    = $clog2(OS_HI);
    localparam int BCNT_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last = (divisor == '0) ? '0 : divisor - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(divisor) > 1 && divisor > 1) |=> !tick);
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
    import urx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx,
    input  logic                os_sel,
    input  logic [BCNT_W-1:0]   nbits,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic [1:0]          nstop,
    output logic                done,
    output logic [MAX_BITS-1:0] fr_data,
    output logic                fr_perr,
    output logic                fr_ferr
);
    rx_state_e state_q, state_d;

    logic [OSC_W-1:0]    os_cnt;
    logic [OSC_W-1:0]    os_last;
    logic [OSC_W-1:0]    os_mid;
    logic [BCNT_W-1:0]   bit_cnt;
    logic [2:0]          smp;
    logic                maj;
    logic                bit_end;
    logic                last_data;
    logic                last_stop;
    logic [MAX_BITS-1:0] shreg;
    logic                par_acc;
    logic                perr_q;
    logic                ferr_q;

    assign os_last   = os_sel ? OSC_W'(OS_LO - 1) : OSC_W'(OS_HI - 1);
    assign os_mid    = os_sel ? OSC_W'(OS_LO / 2) : OSC_W'(OS_HI / 2);
    assign maj       = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
    assign bit_end   = tick && (os_cnt == os_last);
    assign last_data = (bit_cnt == nbits - 1'b1);
    assign last_stop = (bit_cnt[1:0] == nstop - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !rx) state_d = ST_START;
            ST_START: begin
                if (tick && os_cnt == os_mid && rx) state_d = ST_IDLE;
                else if (bit_end)                   state_d = ST_DATA;
            end
            ST_DATA:   if (bit_end && last_data) state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (bit_end && last_stop) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            smp     <= '1;
            shreg   <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            done    <= 1'b0;
            fr_data <= '0;
            fr_perr <= 1'b0;
            fr_ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE)
                os_cnt <= '0;
            else if (tick)
                os_cnt <= (os_cnt == os_last) ? '0 : os_cnt + 1'b1;

            if (state_q != state_d)  bit_cnt <= '0;
            else if (bit_end)        bit_cnt <= bit_cnt + 1'b1;

            if (tick) begin
                if (os_cnt == os_mid - 1'b1) smp[0] <= rx;
                if (os_cnt == os_mid)        smp[1] <= rx;
                if (os_cnt == os_mid + 1'b1) smp[2] <= rx;
            end

            unique case (state_q)
                ST_IDLE: ;
                ST_START: begin
                    shreg   <= '0;
                    par_acc <= 1'b0;
                    perr_q  <= 1'b0;
                    ferr_q  <= 1'b0;
                end
                ST_DATA: if (bit_end) begin
                    shreg   <= {maj, shreg[MAX_BITS-1:1]};
                    par_acc <= par_acc ^ maj;
                end
                ST_PARITY: if (bit_end) perr_q <= maj ^ par_acc ^ par_odd;
                ST_STOP: if (bit_end) begin
                    if (!maj) ferr_q <= 1'b1;
                    if (last_stop) begin
                        done    <= 1'b1;
                        fr_data <= shreg >> (BCNT_W'(MAX_BITS) - nbits);
                        fr_perr <= perr_q;
                        fr_ferr <= ferr_q | !maj;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_bitcnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (bit_cnt < nbits));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import urx_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_line,
    input  logic [DIV_W-1:0]    divisor,
    input  logic                os_sel,
    input  logic [3:0]          data_bits,
    input  logic [1:0]          parity_mode,
    input  logic [1:0]          stop_bits,
    input  logic                addr_mode,
    input  logic [ADR_W-1:0]    node_addr,
    input  logic                rd_pulse,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                data_ready,
    output logic                err_frame,
    output logic                err_parity,
    output logic                err_overrun,
    output logic                rts
);
    logic                rx_s;
    logic                tick;
    logic [BCNT_W-1:0]   nbits;
    logic [1:0]          nstop;
    logic                par_en;
    logic                done;
    logic [MAX_BITS-1:0] fr_data;
    logic                fr_perr;
    logic                fr_ferr;
    logic                filter_on;
    logic                is_addr;
    logic                addr_hit;
    logic                listen_q;
    logic                accept;
    logic                load;

    assign nbits  = (data_bits < 4'(MIN_BITS)) ? BCNT_W'(MIN_BITS) :
                    (data_bits > 4'(MAX_BITS)) ? BCNT_W'(MAX_BITS) : data_bits;
    assign nstop  = (stop_bits == 2'd0) ? 2'd1 : stop_bits;
    assign par_en = (parity_mode == 2'b01) || (parity_mode == 2'b10);

    urx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    urx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    urx_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .os_sel(os_sel),
        .nbits(nbits), .par_en(par_en), .par_odd(parity_mode[1]), .nstop(nstop),
        .done(done), .fr_data(fr_data), .fr_perr(fr_perr), .fr_ferr(fr_ferr)
    );

    assign filter_on = addr_mode && (nbits == BCNT_W'(MAX_BITS));
    assign is_addr   = fr_data[MAX_BITS-1];
    assign addr_hit  = (fr_data[ADR_W-1:0] == node_addr);
    assign accept    = !filter_on || (is_addr ? addr_hit : listen_q);
    assign load      = done && accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            listen_q    <= 1'b0;
            rx_data     <= '0;
            data_ready  <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (done && filter_on && is_addr) listen_q <= addr_hit;

            if (err_clr) begin
                err_frame   <= 1'b0;
                err_parity  <= 1'b0;
                err_overrun <= 1'b0;
            end

            if (load && data_ready && !rd_pulse) begin
                err_overrun <= 1'b1;
            end else if (load) begin
                rx_data    <= fr_data;
                data_ready <= 1'b1;
                if (fr_ferr) err_frame  <= 1'b1;
                if (fr_perr) err_parity <= 1'b1;
            end else if (rd_pulse) begin
                data_ready <= 1'b0;
            end
        end
    end

    assign rts = !data_ready;

    assert_perr_needs_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_parity) |-> $past(par_en));
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_pulse) |=> $stable(rx_data));
    assert_ready_falls_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(rd_pulse));
    assert_overrun_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(data_ready));
    assert_rts_low_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> !rts);
endmodule

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic [11:0] divisor = 12'd4;
    logic        os_sel = 1'b0;
    logic [3:0]  data_bits = 4'd8;
    logic [1:0]  parity_mode = 2'b00;
    logic [1:0]  stop_bits = 2'd1;
    logic        addr_mode = 1'b0;
    logic [7:0]  node_addr = 8'h42;
    logic        rd_pulse = 1'b0;
    logic        err_clr = 1'b0;
    logic [8:0]  rx_data;
    logic        data_ready, err_frame, err_parity, err_overrun, rts;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    serial_rx_core #(.DIV_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .divisor(divisor),
        .os_sel(os_sel), .data_bits(data_bits), .parity_mode(parity_mode),
        .stop_bits(stop_bits), .addr_mode(addr_mode), .node_addr(node_addr),
        .rd_pulse(rd_pulse), .err_clr(err_clr), .rx_data(rx_data),
        .data_ready(data_ready), .err_frame(err_frame), .err_parity(err_parity),
        .err_overrun(err_overrun), .rts(rts)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bitclk();
        int d = (divisor == 0) ? 1 : int'(divisor);
        return d * (os_sel ? 8 : 16);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive_bit(input logic v);
        rx_line = v;
        wait_clk(bitclk());
    endtask

    // frame with nb data bits; bad_par flips parity; bad_stop drives first stop low
    task automatic send_frame(input logic [8:0] val, input int nb, input int nst,
                              input bit bad_par, input bit bad_stop);
        logic p = 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(val[i]);
            p ^= val[i];
        end
        if (parity_mode == 2'b01) drive_bit(p ^ bad_par);
        if (parity_mode == 2'b10) drive_bit(~p ^ bad_par);
        for (int i = 0; i < nst; i++) drive_bit(!(bad_stop && i == 0));
        rx_line = 1'b1;
        wait_clk(24);
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(posedge clk); #1 rd_pulse = 1'b1;
        @(posedge clk); #1 rd_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1 err_clr = 1'b1;
        @(posedge clk); #1 err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R5 reset data_ready", data_ready, 0);
        check("R9 reset rts", rts, 1);
        check("R10 reset flags", {err_frame, err_parity, err_overrun}, 0);
    endtask

    task automatic t_basic();
        divisor = 4; os_sel = 0; data_bits = 8; parity_mode = 2'b00; stop_bits = 1;
        send_frame(9'h0A5, 8, 1, 0, 0);
        check("R1 R3 8N1 16x data", rx_data, 9'h0A5);
        check("R5 data_ready set", data_ready, 1);
        check("R9 rts low while full", rts, 0);
        check("R4 no flags", {err_frame, err_parity, err_overrun}, 0);
        pulse_rd();
        check("R5 read clears ready", data_ready, 0);
        check("R9 rts high after read", rts, 1);
    endtask

    task automatic t_5bit_8x();
        os_sel = 1; data_bits = 5; parity_mode = 2'b01; stop_bits = 2;
        send_frame(9'h013, 5, 2, 0, 0);
        check("R1 R3 5E2 8x data", rx_data, 9'h013);
        check("R2 good even parity", err_parity, 0);
        check("R4 two stop bits ok", err_frame, 0);
        pulse_rd();
        data_bits = 4'd2;
        send_frame(9'h00A, 5, 2, 0, 0);
        check("R1 width below 5 acts as 5", rx_data, 9'h00A);
        pulse_rd();
        os_sel = 0; data_bits = 5;
    endtask

    task automatic t_parity_err();
        data_bits = 7; parity_mode = 2'b10; stop_bits = 3;
        send_frame(9'h05B, 7, 3, 0, 0);
        check("R2 R4 7O3 data", rx_data, 9'h05B);
        check("R2 good odd parity", err_parity, 0);
        pulse_rd();
        send_frame(9'h05B, 7, 3, 1, 0);
        check("R2 bad odd parity flagged", err_parity, 1);
        check("R2 data still delivered", rx_data, 9'h05B);
        pulse_rd();
        pulse_clr();
        check("R10 clear parity flag", err_parity, 0);
    endtask

    task automatic t_frame_err();
        data_bits = 8; parity_mode = 2'b00; stop_bits = 1;
        send_frame(9'h03C, 8, 1, 0, 1);
        check("R4 low stop sets err_frame", err_frame, 1);
        check("R4 data delivered on frame err", rx_data, 9'h03C);
        check("R2 no parity flag without parity", err_parity, 0);
        pulse_rd();
        pulse_clr();
        check("R10 clear frame flag", err_frame, 0);
    endtask

    task automatic t_overrun();
        send_frame(9'h011, 8, 1, 0, 0);
        send_frame(9'h022, 8, 1, 0, 0);
        check("R6 overrun flagged", err_overrun, 1);
        check("R6 old data kept", rx_data, 9'h011);
        pulse_rd();
        pulse_clr();
        check("R10 clear overrun", err_overrun, 0);
        check("R5 ready cleared", data_ready, 0);
    endtask

    task automatic t_glitch();
        rx_line = 1'b0;
        wait_clk(12);
        rx_line = 1'b1;
        wait_clk(2 * bitclk());
        @(negedge clk);
        check("R7 glitch no data", data_ready, 0);
        check("R7 glitch no flags", {err_frame, err_parity, err_overrun}, 0);
        send_frame(9'h0E7, 8, 1, 0, 0);
        check("R7 frame after glitch", rx_data, 9'h0E7);
        pulse_rd();
    endtask

    task automatic t_addr();
        addr_mode = 1; data_bits = 9; node_addr = 8'h42;
        send_frame(9'h055, 9, 1, 0, 0);
        check("R8 data dropped before address", data_ready, 0);
        send_frame(9'h142, 9, 1, 0, 0);
        check("R8 matching address delivered", rx_data, 9'h142);
        pulse_rd();
        send_frame(9'h066, 9, 1, 0, 0);
        check("R8 data after match", rx_data, 9'h066);
        check("R8 data ready after match", data_ready, 1);
        pulse_rd();
        send_frame(9'h113, 9, 1, 0, 0);
        check("R8 other address dropped", data_ready, 0);
        send_frame(9'h077, 9, 1, 0, 0);
        check("R8 data dropped after other address", data_ready, 0);
        check("R8 no flags on drop", {err_frame, err_parity, err_overrun}, 0);
        addr_mode = 0; data_bits = 8;
    endtask

    task automatic t_divisor();
        divisor = 2; os_sel = 0;
        send_frame(9'h0C3, 8, 1, 0, 0);
        check("R3 divisor 2 data", rx_data, 9'h0C3);
        pulse_rd();
        divisor = 0; os_sel = 1;
        send_frame(9'h05A, 8, 1, 0, 0);
        check("R3 divisor 0 acts as 1", rx_data, 9'h05A);
        pulse_rd();
        divisor = 4; os_sel = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_basic();
        t_5bit_8x();
        t_parity_err();
        t_frame_err();
        t_overrun();
        t_glitch();
        t_addr();
        t_divisor();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule